// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which of several interrupt request lines a small CPU core should service next. Each source has a 2-bit priority field. The block latches a rising edge on each request line and holds it pending. It tracks a global enable flag and a stack of the priority levels of the handlers currently in service. A pending request interrupts the running code only when the flag is set and the request's level is strictly more urgent than the handler at the top of the stack.

The CPU drives three one-cycle strobes. One sets the enable flag. One returns from a handler. One marks a retired instruction. When the controller accepts a request, it pulses `take_o` for one cycle and presents the winning source number. The CPU then fetches the vector and saves context itself.

After a return that lands back in the main program, the controller waits for one retired main-program instruction before it accepts anything still pending. This guarantees forward progress in the main program.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source i takes its level from `prio_i[2i+1:2i]`. Level 0 is the most urgent and level 3 the least. Among the eligible pending sources, the one with the numerically smallest level is accepted.
- R2: An acceptance sets `take_o` high for exactly one cycle, with the source number on `take_idx_o`. It also clears the enable flag, so no further acceptance occurs until the flag is set again.
- R3: A pulse on `ei_i` sets the enable flag. The flag affects acceptance from the following cycle onward.
- R4: A pending request whose level is numerically greater than or equal to the level in service is not accepted, even with the flag set. It stays pending.
- R5: A pulse on `reti_i` sets the enable flag and pops one level off the in-service stack. No acceptance takes place in the cycle of the pulse.
- R6: When `reti_i` empties the stack, no request is accepted until a `retire_i` pulse has been seen. The earliest acceptance is decided in the cycle after that pulse.
- R7: Nesting chains across all four levels (3, then 2, then 1, then 0), using a stack at least four entries deep. An empty stack accepts any level.
- R8: Among pending sources of equal best level, the lowest index wins. The winner's pending latch clears on the edge that raises `take_o`, so it is never taken twice for one request.
- R9: Requests are captured on a rising edge only. A line held high yields one acceptance. A captured request stays pending until it is accepted.
- R10: Reset (synchronous, active high) clears all pending latches, the enable flag and the stack, and drives `take_o` low.
- R11: A request whose line is first seen high at clock edge N is latched at N. If nothing blocks it, `take_o` rises at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | Interrupt request lines, edge captured |
| prio_i | input | 2*NSRC | Per-source 2-bit levels, source i at bits 2i+1:2i |
| ei_i | input | 1 | Enable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| retire_i | input | 1 | Instruction-retired strobe |
| take_o | output | 1 | One-cycle acceptance pulse |
| take_idx_o | output | $clog2(NSRC) | Index of the accepted source |

## Verification
The hardest state to reach is a full four-deep nest with requests still parked behind it. Those requests have equal or lower level, or they tie with each other. They are then released one at a time as the stack unwinds, and the last one waits out the one-instruction gate after the return to main.

The stimulus table builds this state in stages. It re-enables interrupts inside each handler before raising the next, more urgent request. It parks level-3, level-2 and level-1 requests along the way. It then issues returns and checks which source wins at each level, and it checks that nothing is accepted before the retire pulse.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef logic [1:0] lvl_t;
  // level value one beyond the least urgent: means "main program"
  localparam logic [2:0] LVL_MAIN = 3'd4;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]   pend_i,
  input  logic [2*NSRC-1:0] prio_i,
  input  logic [2:0]        cur_lvl_i,
  output logic              found_o,
  output logic [IW-1:0]     idx_o,
  output logic [1:0]        lvl_o
);
  logic [2:0] best;

  always_comb begin
    best    = irq_pkg::LVL_MAIN;
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      // strict compare keeps the lowest index on a tie
      if (pend_i[i] && ({1'b0, prio_i[2*i +: 2]} < best) &&
          ({1'b0, prio_i[2*i +: 2]} < cur_lvl_i)) begin
        best    = {1'b0, prio_i[2*i +: 2]};
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
    lvl_o = best[1:0];
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  irq_pkg::lvl_t push_lvl_i,
  input  logic          pop_i,
  output logic [2:0]    cur_lvl_o,
  output logic          to_main_o,
  output logic [CW-1:0] cnt_o
);
  irq_pkg::lvl_t mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] top;
  logic          full;
  logic          empty;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign top   = cnt - 1'b1;

  always_ff @(posedge clk) begin
    if (push_i && !full) mem[cnt[PW-1:0]] <= push_lvl_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (push_i && !full) cnt <= cnt + 1'b1;
    else if (pop_i && !empty) cnt <= cnt - 1'b1;
  end

  assign cur_lvl_o = empty ? irq_pkg::LVL_MAIN : {1'b0, mem[top[PW-1:0]]};
  assign to_main_o = pop_i && (cnt == CW'(1));
  assign cnt_o     = cnt;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC  = 8,
  parameter int DEPTH = 4,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   req_i,
  input  logic [2*NSRC-1:0] prio_i,
  input  logic              ei_i,
  input  logic              reti_i,
  input  logic              retire_i,
  output logic              take_o,
  output logic [IW-1:0]     take_idx_o
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] clr;
  logic            found;
  logic [IW-1:0]   win_idx;
  logic [1:0]      win_lvl;
  logic [2:0]      cur_lvl;
  logic            to_main;
  logic [CW-1:0]   stk_cnt;
  logic            ie_q;
  logic            hold_q;
  logic            grant;

  assign grant = found && ie_q && !hold_q && !reti_i;

  always_comb begin
    clr = '0;
    if (grant) clr[win_idx] = 1'b1;
  end

  irq_edge_latch #(.NSRC(NSRC)) u_latch (
    .clk(clk), .rst(rst), .req_i(req_i), .clr_i(clr), .pend_o(pend)
  );

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .pend_i(pend), .prio_i(prio_i), .cur_lvl_i(cur_lvl),
    .found_o(found), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  irq_lvl_stack #(.DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push_i(grant), .push_lvl_i(win_lvl),
    .pop_i(reti_i), .cur_lvl_o(cur_lvl), .to_main_o(to_main),
    .cnt_o(stk_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q       <= 1'b0;
      hold_q     <= 1'b0;
      take_o     <= 1'b0;
      take_idx_o <= '0;
    end else begin
      take_o <= grant;
      if (grant) take_idx_o <= win_idx;
      if (grant)                ie_q <= 1'b0;
      else if (ei_i || reti_i)  ie_q <= 1'b1;
      if (to_main)              hold_q <= 1'b1;
      else if (retire_i)        hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC  = 8,
  parameter int DEPTH = 4,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [2*NSRC-1:0] prio_i,
  input logic              reti_i,
  input logic              take_o,
  input logic [IW-1:0]     take_idx_o,
  input logic              ie_q,
  input logic              hold_q,
  input logic [2:0]        cur_lvl,
  input logic [CW-1:0]     stk_cnt
);
  logic [2*NSRC-1:0] prio_prev;
  logic [2:0]        lvl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_prev <= '0;
      lvl_prev  <= irq_pkg::LVL_MAIN;
    end else begin
      prio_prev <= prio_i;
      lvl_prev  <= cur_lvl;
    end
  end

  assert_take_clears_en_R2: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !ie_q);
  assert_take_single_R2: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);
  assert_strict_level_R4: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ({1'b0, prio_prev[2*take_idx_o +: 2]} < lvl_prev));
  assert_reti_enables_R5: assert property (@(posedge clk) disable iff (rst)
    reti_i |=> ie_q);
  assert_main_gate_R6: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> !take_o);
  assert_stack_bound_R7: assert property (@(posedge clk) disable iff (rst)
    stk_cnt <= CW'(DEPTH));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .prio_i(prio_i), .reti_i(reti_i),
  .take_o(take_o), .take_idx_o(take_idx_o), .ie_q(ie_q),
  .hold_q(hold_q), .cur_lvl(cur_lvl), .stk_cnt(stk_cnt)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NSRC = 8;
  localparam int IW   = 3;
  localparam int NV   = 34;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NSRC-1:0]   req = '0;
  logic [2*NSRC-1:0] prio;
  logic              ei = 1'b0, reti = 1'b0, retire = 1'b0;
  logic              take;
  logic [IW-1:0]     tidx;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  // levels: src0=3 src1=2 src2=1 src3=0 src4=2 src5=3 src6=2 src7=1
  assign prio = {2'd1, 2'd2, 2'd3, 2'd2, 2'd0, 2'd1, 2'd2, 2'd3};

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC), .DEPTH(4)) u_prio_irq_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .prio_i(prio), .ei_i(ei),
    .reti_i(reti), .retire_i(retire), .take_o(take), .take_idx_o(tidx)
  );

  // {tag, req, ei, reti, retire, exp_take, exp_idx}
  localparam logic [18:0] VEC [NV] = '{
    {4'd3,  8'h00, 3'b100, 1'b0, 3'd0}, // R3 enable
    {4'd11, 8'h01, 3'b000, 1'b0, 3'd0}, // R11 src0 rises
    {4'd11, 8'h00, 3'b000, 1'b1, 3'd0}, // R11 taken next edge
    {4'd2,  8'h02, 3'b000, 1'b0, 3'd0}, // R2 src1 while disabled
    {4'd2,  8'h00, 3'b000, 1'b0, 3'd0}, // R2
    {4'd3,  8'h00, 3'b100, 1'b0, 3'd0}, // R3 ei not yet effective
    {4'd7,  8'h00, 3'b000, 1'b1, 3'd1}, // R7 level 2 nests over 3
    {4'd3,  8'h00, 3'b100, 1'b0, 3'd0},
    {4'd4,  8'h20, 3'b000, 1'b0, 3'd0}, // R4 lower level parked
    {4'd4,  8'h00, 3'b000, 1'b0, 3'd0},
    {4'd4,  8'h10, 3'b000, 1'b0, 3'd0}, // R4 equal level parked
    {4'd4,  8'h00, 3'b000, 1'b0, 3'd0},
    {4'd8,  8'h84, 3'b000, 1'b0, 3'd0}, // R8 tie src2/src7
    {4'd8,  8'h00, 3'b000, 1'b1, 3'd2},
    {4'd3,  8'h00, 3'b100, 1'b0, 3'd0},
    {4'd4,  8'h00, 3'b000, 1'b0, 3'd0},
    {4'd7,  8'h08, 3'b000, 1'b0, 3'd0}, // R7 level 0
    {4'd7,  8'h00, 3'b000, 1'b1, 3'd3},
    {4'd5,  8'h00, 3'b010, 1'b0, 3'd0}, // R5 pop to 1
    {4'd5,  8'h00, 3'b000, 1'b0, 3'd0},
    {4'd5,  8'h00, 3'b010, 1'b0, 3'd0}, // R5 pop to 2
    {4'd1,  8'h00, 3'b000, 1'b1, 3'd7}, // R1 level1 src7
    {4'd5,  8'h00, 3'b010, 1'b0, 3'd0},
    {4'd4,  8'h00, 3'b000, 1'b0, 3'd0},
    {4'd5,  8'h00, 3'b010, 1'b0, 3'd0}, // pop to 3
    {4'd1,  8'h00, 3'b000, 1'b1, 3'd4}, // R1 src4 over src5
    {4'd5,  8'h00, 3'b010, 1'b0, 3'd0},
    {4'd5,  8'h00, 3'b010, 1'b0, 3'd0}, // back to main
    {4'd6,  8'h00, 3'b000, 1'b0, 3'd0}, // R6 gated
    {4'd6,  8'h00, 3'b000, 1'b0, 3'd0},
    {4'd6,  8'h00, 3'b001, 1'b0, 3'd0}, // R6 retire
    {4'd6,  8'h00, 3'b000, 1'b1, 3'd5},
    {4'd5,  8'h00, 3'b010, 1'b0, 3'd0},
    {4'd9,  8'h00, 3'b001, 1'b0, 3'd0}  // R9 nothing left
  };

  task automatic step(input logic [NSRC-1:0] r, input logic e,
                      input logic rt, input logic rr);
    @(negedge clk);
    req = r; ei = e; reti = rt; retire = rr;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic et, input logic [IW-1:0] ei_x,
                       input string tag);
    n_chk++;
    if (take !== et || (et && tidx !== ei_x)) begin
      n_fail++;
      $display("FAIL %s: take=%0b idx=%0d expected take=%0b idx=%0d",
               tag, take, tidx, et, ei_x);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected<=5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, '0, "R10");
    @(negedge clk); rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][14:7], VEC[v][6], VEC[v][5], VEC[v][4]);
      check(VEC[v][3], VEC[v][2:0], $sformatf("R%0d", VEC[v][18:15]));
    end
    // R10: reset wipes a pending request
    step(8'h01, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1; req = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    step(8'h00, 1'b1, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b0, 1'b0); check(1'b0, '0, "R10");
    step(8'h00, 1'b0, 1'b0, 1'b0); check(1'b0, '0, "R10");
    // R1: mixed levels, most urgent wins
    step(8'h09, 1'b0, 1'b0, 1'b0); check(1'b0, '0, "R1");
    step(8'h00, 1'b0, 1'b0, 1'b0); check(1'b1, 3'd3, "R1");
    step(8'h00, 1'b0, 1'b1, 1'b0); check(1'b0, '0, "R5");
    step(8'h00, 1'b0, 1'b0, 1'b1); check(1'b0, '0, "R6");
    step(8'h00, 1'b0, 1'b0, 1'b0); check(1'b1, 3'd0, "R9");
    step(8'h00, 1'b0, 1'b1, 1'b0); check(1'b0, '0, "R5");
    step(8'h00, 1'b0, 1'b0, 1'b1); check(1'b0, '0, "R6");
    // R9: held line gives one acceptance
    step(8'h40, 1'b0, 1'b0, 1'b0); check(1'b0, '0, "R9");
    step(8'h40, 1'b0, 1'b0, 1'b0); check(1'b1, 3'd6, "R9");
    step(8'h40, 1'b0, 1'b1, 1'b0); check(1'b0, '0, "R9");
    step(8'h40, 1'b0, 1'b0, 1'b1); check(1'b0, '0, "R9");
    step(8'h40, 1'b0, 1'b0, 1'b0); check(1'b0, '0, "R9");
    step(8'h00, 1'b0, 1'b0, 1'b0); check(1'b0, '0, "R9");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule